// File: doc/BRIEF.md
# SMBus Slave Receive Engine

This block is the receive side of a two-wire serial slave. It samples the clock and data lines with a fast system clock and recognises START and STOP conditions. It then collects the address byte and its direction bit. When the direction is write, it passes each received byte to a host through a small register-style interface. Matching the address is left to the host. The host accepts or refuses every byte, the address included, through its acknowledge decision.

After the eighth bit of a byte, the engine latches the byte and raises an interrupt. It then holds the clock line low until the host writes its decision. During the ninth clock it drives that decision onto the data line. A refusal sends the engine into a quiet state, which it leaves only on a new START or a STOP. A write to the data register by the host while a write transfer is active raises a request flag for the transmit side, which is outside this block.

Top module: `smb_slave_rx`

## Requirements
- R1: After reset, neither bus line is pulled and irq, ack_req, rx_active and xmit_req are 0.
- R2: With inhibit low, a START followed by an address byte whose bit 0 is 0 (write) sets irq and ack_req before the ninth clock. It sets rx_active, sets byte_is_addr to 1, and makes rx_byte equal the full eight received bits.
- R3: Once SCL goes low after the eighth bit of an accepted byte, the block holds SCL low (scl_pull=1) until the host pulses ack_wr.
- R4: If ack_ok=1 at the ack_wr pulse, SDA is held low throughout the ninth SCL high period. If ack_ok=0, SDA stays released. The block changes sda_pull only while SCL is low.
- R5: Data bytes after an acknowledged address are taken MSB first on rising SCL. Each one sets irq and ack_req with byte_is_addr=0 before its acknowledge clock.
- R6: After the host refuses an address, rx_active is 0. Later bytes raise no interrupt and no clock stretch until a new START, after which address reception works again.
- R7: An address byte whose bit 0 is 1 (read) raises no interrupt and causes no stretch, and the rest of the transfer is ignored.
- R8: A START seen while inhibit is high is ignored: no interrupt and no stretch for that transfer.
- R9: A STOP clears rx_active and releases both lines.
- R10: A repeated START in the middle of a transfer restarts address reception without a STOP.
- R11: A data_wr pulse while rx_active is 1 sets xmit_req. A data_wr pulse while rx_active is 0 has no effect. START and STOP clear xmit_req.
- R12: irq and rx_byte hold through the acknowledge cycle until the host pulses irq_clr, which clears irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| inhibit | input | 1 | 1 = ignore slave events at START |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_pull | output | 1 | 1 = pull SDA low (acknowledge) |
| rx_byte | output | 8 | Last received byte |
| byte_is_addr | output | 1 | rx_byte is an address byte |
| irq | output | 1 | Byte-received interrupt flag |
| ack_req | output | 1 | Acknowledge decision pending |
| ack_wr | input | 1 | Host pulse writing the decision |
| ack_ok | input | 1 | Decision value: 1 = ACK, 0 = NACK |
| irq_clr | input | 1 | Host pulse clearing irq |
| data_wr | input | 1 | Host pulse writing the data register |
| rx_active | output | 1 | Write transfer in progress |
| xmit_req | output | 1 | Host asked for transmit direction |

## Verification
A change on a bus line reaches the control logic after three clock edges: two synchronizer flops and an edge register. Flags, the stretch and the acknowledge drive therefore show up on the fourth edge at most after the line event. Host pulses act on the next edge. The bench drives its bus model in quarter-bit steps of ten cycles and checks each result only after a full quarter-bit has passed, so every check falls well past its due cycle. All inputs change and all outputs are sampled on falling clock edges.

// File: rtl/smb_slave_rx.sv
module smb_slave_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inhibit,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic [7:0] rx_byte,
  output logic       byte_is_addr,
  output logic       irq,
  output logic       ack_req,
  input  logic       ack_wr,
  input  logic       ack_ok,
  input  logic       irq_clr,
  input  logic       data_wr,
  output logic       rx_active,
  output logic       xmit_req
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DATA, S_WAIT, S_ACK, S_SKIP} st_t;
  st_t st;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [2:0] cnt;
  logic [7:0] sr;
  logic       stretch, sda_drv, ack_dec, ack_on;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign scl_pull = stretch;
  assign sda_pull = sda_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= 3'd0;
      sr           <= 8'd0;
      rx_byte      <= 8'd0;
      byte_is_addr <= 1'b0;
      irq          <= 1'b0;
      ack_req      <= 1'b0;
      stretch      <= 1'b0;
      sda_drv      <= 1'b0;
      ack_dec      <= 1'b0;
      ack_on       <= 1'b0;
      rx_active    <= 1'b0;
      xmit_req     <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (data_wr && rx_active) xmit_req <= 1'b1;
      if (start_det || stop_det) begin
        stretch   <= 1'b0;
        sda_drv   <= 1'b0;
        ack_req   <= 1'b0;
        ack_on    <= 1'b0;
        cnt       <= 3'd0;
        rx_active <= 1'b0;
        xmit_req  <= 1'b0;
        st        <= stop_det ? S_IDLE : (inhibit ? S_SKIP : S_ADDR);
      end else begin
        case (st)
          S_ADDR, S_DATA:
            if (scl_rise) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                if (st == S_DATA || !sda_s) begin
                  rx_byte      <= {sr[6:0], sda_s};
                  byte_is_addr <= (st == S_ADDR);
                  irq          <= 1'b1;
                  ack_req      <= 1'b1;
                  if (st == S_ADDR) rx_active <= 1'b1;
                  st <= S_WAIT;
                end else begin
                  st <= S_SKIP;
                end
              end
            end
          S_WAIT: begin
            if (!scl_s && !ack_wr) stretch <= 1'b1;
            if (ack_wr) begin
              ack_req <= 1'b0;
              ack_dec <= ack_ok;
              st      <= S_ACK;
            end
          end
          S_ACK:
            if (!ack_on) begin
              if (!scl_s) begin
                sda_drv <= ack_dec;
                ack_on  <= 1'b1;
              end
            end else begin
              stretch <= 1'b0;
              if (scl_fall) begin
                sda_drv <= 1'b0;
                ack_on  <= 1'b0;
                cnt     <= 3'd0;
                st      <= ack_dec ? S_DATA : S_SKIP;
                if (!ack_dec && byte_is_addr) rx_active <= 1'b0;
              end
            end
          default: ;
        endcase
      end
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_s)); // R4
  AST_STRETCH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull) |-> ack_req); // R3
  AST_REQ_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_req) |-> irq); // R2
  AST_ACTIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> (byte_is_addr && !rx_byte[0])); // R2
  AST_XREQ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmit_req) |-> $past(rx_active)); // R11
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!scl_pull && !sda_pull)); // R9
endmodule

// File: tb/smb_slave_rx_tb_top.sv
module smb_slave_rx_tb_top;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic inhibit = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic ack_wr = 1'b0, ack_ok = 1'b0, irq_clr = 1'b0, data_wr = 1'b0;
  logic scl_pull, sda_pull, byte_is_addr, irq, ack_req, rx_active, xmit_req;
  logic [7:0] rx_byte;
  logic scl_in, sda_in;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  assign scl_in = scl_m & ~scl_pull;
  assign sda_in = sda_m & ~sda_pull;

  smb_slave_rx dut_i (.clk(clk), .rst_n(rst_n), .inhibit(inhibit), .scl_in(scl_in),
    .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull), .rx_byte(rx_byte),
    .byte_is_addr(byte_is_addr), .irq(irq), .ack_req(ack_req), .ack_wr(ack_wr),
    .ack_ok(ack_ok), .irq_clr(irq_clr), .data_wr(data_wr), .rx_active(rx_active),
    .xmit_req(xmit_req));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int k = 1);
    repeat (k * Q) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wait (scl_in); wq();
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wq(); scl_m = 1'b1; wait (scl_in); wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic m_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wait (scl_in); wq(2);
      scl_m = 1'b0; wq();
    end
    sda_m = 1'b1;
  endtask

  task automatic pulse_host(ref logic sig);
    @(negedge clk); sig = 1'b1; @(negedge clk); sig = 1'b0;
  endtask

  task automatic ack_phase(input bit exp_irq, input logic [7:0] exp_byte,
                           input bit exp_addr, input bit host_ack, input string ntag);
    string tg;
    tg = exp_addr ? "R2 addr" : "R5 data";
    wq(2);
    if (exp_irq) begin
      chk({tg, " irq"}, irq, 1);
      chk({tg, " ack_req"}, ack_req, 1);
      chk({tg, " rx_byte"}, rx_byte, exp_byte);
      chk({tg, " byte_is_addr"}, byte_is_addr, exp_addr);
      scl_m = 1'b1; wq(3);
      chk("R3 scl stretched", scl_in, 0);
      @(negedge clk); ack_ok = host_ack; ack_wr = 1'b1;
      @(negedge clk); ack_wr = 1'b0;
    end else begin
      chk({ntag, " no irq"}, irq, 0);
      scl_m = 1'b1; wq();
      chk({ntag, " no stretch"}, scl_in, 1);
    end
    wait (scl_in); wq();
    chk("R4 sda at ninth clock", sda_in, (exp_irq && host_ack) ? 0 : 1);
    scl_m = 1'b0; wq();
    if (exp_irq) begin
      chk("R12 irq held", irq, 1);
      chk("R12 rx_byte held", rx_byte, exp_byte);
      pulse_host(irq_clr); @(negedge clk);
      chk("R12 irq cleared", irq, 0);
    end
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    chk("R1 scl_pull", scl_pull, 0);
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ack_req", ack_req, 0);
    chk("R1 rx_active", rx_active, 0);
    chk("R1 xmit_req", xmit_req, 0);
  endtask

  task automatic t_write;
    m_start; m_byte(8'hA4);
    ack_phase(1, 8'hA4, 1, 1, "");
    chk("R2 rx_active", rx_active, 1);
    m_byte(8'h3C); ack_phase(1, 8'h3C, 0, 1, "");
    m_byte(8'hC5); ack_phase(1, 8'hC5, 0, 0, "");
    m_stop; wq();
    chk("R9 rx_active cleared", rx_active, 0);
    chk("R9 lines released", {scl_pull, sda_pull}, 0);
  endtask

  task automatic t_nack_addr;
    m_start; m_byte(8'h52);
    ack_phase(1, 8'h52, 1, 0, "");
    chk("R6 rx_active after NACK", rx_active, 0);
    m_byte(8'h0F); ack_phase(0, 8'h00, 0, 0, "R6");
    m_start; m_byte(8'h10);
    ack_phase(1, 8'h10, 1, 1, "");
    chk("R6 active again after START", rx_active, 1);
    m_stop; wq();
  endtask

  task automatic t_read_addr;
    m_start; m_byte(8'h91);
    ack_phase(0, 8'h00, 0, 0, "R7");
    chk("R7 rx_active", rx_active, 0);
    m_stop; wq();
  endtask

  task automatic t_inhibit;
    inhibit = 1'b1;
    m_start; m_byte(8'h20);
    ack_phase(0, 8'h00, 0, 0, "R8");
    chk("R8 rx_active", rx_active, 0);
    inhibit = 1'b0;
    m_stop; wq();
  endtask

  task automatic t_restart;
    m_start; m_byte(8'h40); ack_phase(1, 8'h40, 1, 1, "");
    m_byte(8'h77); ack_phase(1, 8'h77, 0, 1, "");
    m_start; m_byte(8'h42);
    wq(2);
    chk("R10 irq on restart", irq, 1);
    chk("R10 rx_byte", rx_byte, 8'h42);
    chk("R10 byte_is_addr", byte_is_addr, 1);
    ack_phase(1, 8'h42, 1, 1, "");
    pulse_host(data_wr); @(negedge clk);
    chk("R11 xmit_req set", xmit_req, 1);
    m_stop; wq();
    chk("R11 xmit_req cleared by STOP", xmit_req, 0);
    chk("R9 rx_active cleared", rx_active, 0);
    pulse_host(data_wr); wq();
    chk("R11 data_wr idle ignored", xmit_req, 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary;
  end

  initial begin
    t_reset;
    t_write;
    t_nack_addr;
    t_read_addr;
    t_inhibit;
    t_restart;
    summary;
  end
endmodule